// File: doc/BRIEF.md
# Serial EEPROM Read-Only Slave

This block acts as the slave side of a three-wire serial EEPROM that holds a station address for a network interface. A host frames each access with a chip-select line. While chip select is high, the host drives a bit on the serial data input for every rising edge of the serial clock. The block waits for a start bit, then takes a two-bit command code and a six-bit word address. After that it returns the addressed 16-bit word on the serial data output, one bit per clock.

Only the read command is accepted. When a word is complete, the block moves on to the next word by itself, so the host can read the whole array in one transaction by keeping chip select high. All other command codes abort the transaction. The storage is a 64-word by 16-bit array. It is filled through a synchronous parallel preload port, and that port only works while chip select is low.

The serial clock is treated as a level that the system clock samples. It must therefore stay high and stay low for at least one system clock each.

Top module: `ee_read_slave`

## Requirements
- R1: Driving chipSel low returns the slave to the idle start state within one system clock. It drives serOut to 0, discards any partly received start, opcode or address, and resets the word address to 0.
- R2: The state changes only on a rising serClk edge seen while chipSel is high. A serClk held high, a falling edge, and serIn changing while serClk is high all have no effect.
- R3: In the start state, a 0 bit on a rising edge leaves the slave waiting. A 1 bit begins opcode reception.
- R4: The opcode is two bits, sent MSB first. Only binary 10 (read) continues. Any other code sends the slave back to the start state, where it needs a fresh start bit.
- R5: After the read opcode, a six-bit word address is shifted in MSB first.
- R6: The addressed word is shifted out MSB first, one bit per rising serClk edge. Each bit appears on serOut one system clock after the edge is sampled and holds until the next rising edge.
- R7: After the 16th bit of a word, the address increments and the next rising edge delivers the MSB of the next word, with no new command.
- R8: During a sequential read, the word address wraps from 63 to 0.
- R9: serOut stays at 0 from reset or deselect until the first data bit is driven.
- R10: A preload write (initWe with initAddr and initData) updates the storage only while chipSel is low. A later read returns the new word. A preload attempted while chipSel is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSel | input | 1 | Serial chip select, active high |
| serClk | input | 1 | Serial clock, sampled by clk |
| serIn | input | 1 | Serial data from host |
| serOut | output | 1 | Serial data to host |
| initWe | input | 1 | Preload write strobe |
| initAddr | input | 6 | Preload word address |
| initData | input | 16 | Preload word value |

## Verification
The bench uses the default parameters: a 6-bit address, a 16-bit word and a 2-bit opcode. At these sizes the whole array can be preloaded with distinct words. A sequential read can then run across the 63-to-0 wrap, and each word returned can be matched to its address. Each serial bit is held high for two system clocks, and serIn is flipped while serClk is high. This exposes any design that samples more than once per edge or samples at the wrong moment.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_OPC   = 2'd1,
    ST_ADDR  = 2'd2,
    ST_DATA  = 2'd3
  } eeState_t;

  typedef struct packed {
    logic clrAll;
    logic shiftOpc;
    logic shiftAddr;
    logic emitBit;
    logic incAddr;
  } eeStrobe_t;
endpackage

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int OPC_W    = 2,
  parameter logic [OPC_W-1:0] READ_OPC = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              serClk,
  input  logic              serIn,
  input  logic [OPC_W-1:0]  opcReg,
  output eeStrobe_t         stb,
  output logic [$clog2(DATA_W)-1:0] bitIdx
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);

  eeState_t   state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic       sclkQ;
  logic       sclkRise;
  logic [OPC_W-1:0] opcFull;

  assign sclkRise = serClk & ~sclkQ;
  assign opcFull  = {opcReg[OPC_W-2:0], serIn};
  assign bitIdx   = IDX_W'(cnt - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= serClk;
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    cntNxt   = cnt;
    if (!chipSel) begin
      stb.clrAll = 1'b1;
      stateNxt   = ST_START;
      cntNxt     = '0;
    end else if (sclkRise) begin
      unique case (state)
        ST_START: begin
          if (serIn) begin
            stateNxt = ST_OPC;
            cntNxt   = '0;
          end
        end
        ST_OPC: begin
          stb.shiftOpc = 1'b1;
          if (cnt == CNT_W'(OPC_W - 1)) begin
            cntNxt = '0;
            if (opcFull == READ_OPC) begin
              stateNxt = ST_ADDR;
            end else begin
              stateNxt   = ST_START;
              stb.clrAll = 1'b1;
            end
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        ST_ADDR: begin
          stb.shiftAddr = 1'b1;
          if (cnt == CNT_W'(ADDR_W - 1)) begin
            stateNxt = ST_DATA;
            cntNxt   = CNT_W'(DATA_W);
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          stb.emitBit = 1'b1;
          if (cnt == CNT_W'(1)) begin
            stb.incAddr = 1'b1;
            cntNxt      = CNT_W'(DATA_W);
          end else begin
            cntNxt = cnt - 1'b1;
          end
        end
        default: begin
          stateNxt   = ST_START;
          stb.clrAll = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_START;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  // R1: deselect forces idle
  p_idle_on_deselect_r1: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> state == ST_START);
  // R2: no rising edge, no progress
  p_hold_without_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !sclkRise) |=> ($stable(state) && $stable(cnt)));
  // R3: zero bit keeps waiting
  p_start_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && sclkRise && state == ST_START && !serIn) |=> state == ST_START);
  // R4: non-read opcode aborts
  p_bad_opcode_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && sclkRise && state == ST_OPC && cnt == CNT_W'(OPC_W - 1)
     && opcFull != READ_OPC) |=> state == ST_START);
  // R6: data bit counter stays in range
  p_data_cnt_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DATA |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(DATA_W)));
endmodule

// File: rtl/ee_datapath.sv
module ee_datapath
  import ee_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int OPC_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              serIn,
  input  eeStrobe_t         stb,
  input  logic [$clog2(DATA_W)-1:0] bitIdx,
  input  logic              initWe,
  input  logic [ADDR_W-1:0] initAddr,
  input  logic [DATA_W-1:0] initData,
  output logic [OPC_W-1:0]  opcReg,
  output logic              serOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] curWord;

  assign curWord = memArr[addrReg];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)
        memArr[gi] <= '0;
      else if (initWe && !chipSel && initAddr == ADDR_W'(gi))
        memArr[gi] <= initData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcReg  <= '0;
      addrReg <= '0;
      serOut  <= 1'b0;
    end else if (stb.clrAll) begin
      opcReg  <= '0;
      addrReg <= '0;
      serOut  <= 1'b0;
    end else begin
      if (stb.shiftOpc)  opcReg  <= {opcReg[OPC_W-2:0], serIn};
      if (stb.shiftAddr) addrReg <= {addrReg[ADDR_W-2:0], serIn};
      if (stb.emitBit)   serOut  <= curWord[bitIdx];
      if (stb.incAddr)   addrReg <= addrReg + 1'b1;
    end
  end

  // R1: clear leaves output low and address at zero
  p_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> (serOut == 1'b0 && addrReg == '0));
  // R9: output only moves on a data strobe
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.emitBit && !stb.clrAll) |=> $stable(serOut));
  // R8: last word rolls over to the first
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incAddr && !stb.clrAll && addrReg == '1) |=> addrReg == '0);
endmodule

// File: rtl/ee_read_slave.sv
module ee_read_slave
  import ee_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int OPC_W  = 2,
  parameter logic [OPC_W-1:0] READ_OPC = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              serClk,
  input  logic              serIn,
  output logic              serOut,
  input  logic              initWe,
  input  logic [ADDR_W-1:0] initAddr,
  input  logic [DATA_W-1:0] initData
);
  localparam int IDX_W = $clog2(DATA_W);

  eeStrobe_t        stb;
  logic [IDX_W-1:0] bitIdx;
  logic [OPC_W-1:0] opcReg;

  ee_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPC_W(OPC_W), .READ_OPC(READ_OPC)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk), .serIn(serIn),
    .opcReg(opcReg), .stb(stb), .bitIdx(bitIdx)
  );

  ee_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPC_W(OPC_W)) u_dp (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serIn(serIn), .stb(stb),
    .bitIdx(bitIdx), .initWe(initWe), .initAddr(initAddr), .initData(initData),
    .opcReg(opcReg), .serOut(serOut)
  );
endmodule

// File: tb/tb_ee_read_slave.sv
module tb_ee_read_slave;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, serClk = 1'b0, serIn = 1'b0;
  logic serOut;
  logic initWe = 1'b0;
  logic [5:0] initAddr = '0;
  logic [15:0] initData = '0;

  int nChecks = 0, nFail = 0;
  logic [15:0] model [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_read_slave dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk), .serIn(serIn),
    .serOut(serOut), .initWe(initWe), .initAddr(initAddr), .initData(initData)
  );

  function automatic logic [15:0] pat(int k);
    return 16'((k * 16'h3B1D) ^ 16'h5A5A);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one serial bit: serIn flips while serClk is high (R2)
  task automatic sendBit(input logic b, output logic outBit);
    @(negedge clk); serIn = b; serClk = 1'b1;
    @(negedge clk); serIn = ~b;
    @(negedge clk); serClk = 1'b0;
    @(negedge clk);
    outBit = serOut;
  endtask

  task automatic deselect();
    @(negedge clk); chipSel = 1'b0;
    waitClk(2);
  endtask

  task automatic select();
    @(negedge clk); chipSel = 1'b1;
    waitClk(1);
  endtask

  task automatic preload(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); initWe = 1'b1; initAddr = a; initData = d;
    @(negedge clk); initWe = 1'b0;
  endtask

  // start + read opcode + address; returns OR of serOut during command
  task automatic sendCmd(input logic [5:0] a, output logic anyOut);
    logic o;
    anyOut = 1'b0;
    sendBit(1'b1, o); anyOut |= o;
    sendBit(1'b1, o); anyOut |= o;
    sendBit(1'b0, o); anyOut |= o;
    for (int i = 5; i >= 0; i--) begin
      sendBit(a[i], o); anyOut |= o;
    end
  endtask

  task automatic readWord(output logic [15:0] w);
    logic o;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      sendBit(1'b0, o);
      w = {w[14:0], o};
    end
  endtask

  task automatic t_reset();
    check(serOut == 1'b0, "R9 reset output low", 16'(serOut), 16'h0);
  endtask

  task automatic t_basic();
    logic any, o;
    logic [15:0] w;
    select();
    for (int i = 0; i < 4; i++) begin
      sendBit(1'b0, o);
      any = o;
      check(o == 1'b0, "R3 zero before start ignored", 16'(o), 16'h0);
    end
    sendCmd(6'd5, any);
    check(any == 1'b0, "R9 output low during command", 16'(any), 16'h0);
    readWord(w);
    check(w == model[5], "R5 R6 single word read addr 5", w, model[5]);
    deselect();
    check(serOut == 1'b0, "R1 deselect drives output low", 16'(serOut), 16'h0);
  endtask

  task automatic t_seq();
    logic any;
    logic [15:0] w;
    select();
    sendCmd(6'd10, any);
    for (int k = 10; k < 13; k++) begin
      readWord(w);
      check(w == model[k], "R7 sequential word", w, model[k]);
    end
    deselect();
  endtask

  task automatic t_wrap();
    logic any;
    logic [15:0] w;
    select();
    sendCmd(6'd62, any);
    readWord(w); check(w == model[62], "R8 word 62", w, model[62]);
    readWord(w); check(w == model[63], "R8 word 63", w, model[63]);
    readWord(w); check(w == model[0],  "R8 wrap to word 0", w, model[0]);
    deselect();
  endtask

  task automatic t_badOpc();
    logic o, any, any2;
    logic [15:0] w;
    select();
    // opcode 11 rejected
    sendBit(1'b1, o); sendBit(1'b1, o); sendBit(1'b1, o);
    any = 1'b0;
    for (int i = 0; i < 24; i++) begin sendBit(1'b0, o); any |= o; end
    check(any == 1'b0, "R4 opcode 11 produces no data", 16'(any), 16'h0);
    // opcode 01 rejected, then fresh command works without deselect
    sendBit(1'b1, o); sendBit(1'b0, o); sendBit(1'b1, o);
    any = 1'b0;
    for (int i = 0; i < 24; i++) begin sendBit(1'b0, o); any |= o; end
    check(any == 1'b0, "R4 opcode 01 produces no data", 16'(any), 16'h0);
    sendCmd(6'd33, any2);
    readWord(w);
    check(w == model[33], "R4 restart after rejected opcode", w, model[33]);
    deselect();
  endtask

  task automatic t_abort();
    logic o, any;
    logic [15:0] w;
    select();
    sendBit(1'b1, o); sendBit(1'b1, o); sendBit(1'b0, o);
    sendBit(1'b1, o); sendBit(1'b1, o); sendBit(1'b1, o);
    deselect();
    select();
    sendCmd(6'd7, any);
    readWord(w);
    check(w == model[7], "R1 partial command discarded", w, model[7]);
    // abort mid-word, then read again from start of a word
    sendBit(1'b0, o); sendBit(1'b0, o);
    deselect();
    select();
    sendCmd(6'd9, any);
    readWord(w);
    check(w == model[9], "R1 mid-word abort then new read", w, model[9]);
    deselect();
  endtask

  task automatic t_noEdge();
    logic any;
    logic [15:0] w;
    // clock activity while deselected has no effect
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); serIn = 1'b1; serClk = 1'b1;
      @(negedge clk); serClk = 1'b0;
    end
    select();
    // long high level counts once
    @(negedge clk); serIn = 1'b0; serClk = 1'b1;
    waitClk(6);
    @(negedge clk); serClk = 1'b0;
    waitClk(1);
    sendCmd(6'd40, any);
    readWord(w);
    check(w == model[40], "R2 level and deselected edges ignored", w, model[40]);
    deselect();
  endtask

  task automatic t_preload();
    logic any;
    logic [15:0] w;
    preload(6'd20, 16'hBEEF);
    model[20] = 16'hBEEF;
    select();
    sendCmd(6'd20, any);
    readWord(w);
    check(w == 16'hBEEF, "R10 preload while deselected", w, 16'hBEEF);
    // preload attempt while selected: ignored
    preload(6'd21, 16'h1234);
    readWord(w);
    check(w == model[21], "R10 preload while selected ignored", w, model[21]);
    deselect();
  endtask

  initial begin
    waitClk(3);
    @(negedge clk); rstN = 1'b1;
    waitClk(1);
    t_reset();
    for (int k = 0; k < 64; k++) begin
      model[k] = pat(k);
      preload(6'(k), pat(k));
    end
    t_basic();
    t_seq();
    t_wrap();
    t_badOpc();
    t_abort();
    t_noEdge();
    t_preload();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule